// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block is the bus-cycle command interpreter of a parallel NOR-style flash in 16-bit word mode. Each write strobe brings a word address and a data word. The decoder follows the multi-write unlock sequences for word program, sector erase, block erase, chip erase, identification entry and identification exit. When a sequence completes, it emits a one-cycle command pulse that carries an operation code, the target address and the program data. The storage array and its timing live elsewhere and act on that pulse.

The decoder also holds the read mode. In array mode the identification word output is zero. In identification mode it returns a manufacturer or device code, selected by one address bit. A write-protect input, active low, refuses program and erase that would touch the four outermost 2-KWord sectors; which end of the map is protected is chosen by a parameter. While the array reports an operation in progress, writes are ignored. The active-low reset returns the decoder to array mode at once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Driving rstN low clears idMode and cmdValid immediately, without waiting for a clock edge, and discards any partly entered sequence.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then one write (A, D) produce cmdValid=1 in the cycle after the last write, with cmdOp=1, cmdAddr=A and cmdData=D (all 16 bits). Whenever cmdValid is 0, cmdOp, cmdAddr and cmdData are 0.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produce a pulse with cmdOp=4, cmdAddr=0 and cmdData=0.
- R4: If the sixth erase write is 30h at address A, the pulse has cmdOp=2 (sector erase). If it is 50h at address A, the pulse has cmdOp=3 (block erase). In both cases cmdAddr=A and cmdData=0.
- R5: The writes AAh@555h, 55h@2AAh, 90h@555h set idMode. While idMode is set, idWord is 7343h when idSel=1 and the manufacturer code 00A7h when idSel=0. In array mode idWord is 0.
- R6: idMode is cleared by a single write of F0h at any address while no sequence is in progress, or by AAh@555h, 55h@2AAh, F0h@555h.
- R7: Command cycles compare only data bits 7:0 and address bits 10:0. The upper data byte and the upper address bits do not affect decoding.
- R8: A write that does not match the next expected step returns the decoder to idle without a command. A later write that would only have completed the broken sequence issues nothing.
- R9: While wpN=0, the following are rejected with no pulse: program or sector erase at a word address below 2000h, block erase inside block 0 (address below 8000h), and chip erase. The same writes with wpN=1 are accepted.
- R10: A write presented while busy=1 is ignored. It issues no pulse and the sequence position is kept.
- R11: cmdValid is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one cycle per bus write |
| wrAddr | input | 20 | Word address of the write |
| wrData | input | 16 | Data of the write |
| wpN | input | 1 | Write protect, active low |
| busy | input | 1 | Internal operation in progress |
| idSel | input | 1 | Selects the device code (1) or the manufacturer code (0) in identification mode |
| cmdValid | output | 1 | One-cycle command pulse |
| cmdOp | output | 3 | Operation: 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| cmdAddr | output | 20 | Target word address |
| cmdData | output | 16 | Program data |
| idMode | output | 1 | 1 while in identification read mode |
| idWord | output | 16 | Identification word |

## Verification
The hardest case to reach is a reset that lands in the middle of a sequence while identification mode is active. The bench first enters identification mode and starts a new unlock. It then drops rstN between clock edges and checks idMode before any edge arrives. After release, it sends the rest of the old program sequence and confirms that nothing is issued. A busy write placed just before the final program write shows that the sequence position survives the ignored write.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  localparam int UNLOCK_AW = 11;
  localparam logic [UNLOCK_AW-1:0] UNLOCK_FIRST  = 11'h555;
  localparam logic [UNLOCK_AW-1:0] UNLOCK_SECOND = 11'h2AA;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_EXIT  = 8'hF0;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_BLK   = 8'h50;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } cmdOp_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS3, S_ERS4, S_ERS5
  } seqState_e;

  typedef struct packed {
    logic       atFirst;
    logic       atSecond;
    logic [7:0] code;
    logic       protSector;
    logic       protBlock;
  } busFlags_t;

  typedef struct packed {
    logic   fire;
    cmdOp_e op;
    logic   setId;
    logic   clrId;
  } ctrlStrobe_t;

endpackage

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        busy,
  input  logic        wpN,
  input  busFlags_t   flags,
  output ctrlStrobe_t strobe
);

  seqState_e state, nextState;
  logic wrGo;

  assign wrGo = wrEn & ~busy;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (wrGo) begin
      nextState = S_IDLE;
      unique case (state)
        S_IDLE: begin
          if (flags.atFirst && flags.code == CODE_KEY1) nextState = S_UNL1;
          else if (flags.code == CODE_EXIT)             strobe.clrId = 1'b1;
        end
        S_UNL1: begin
          if (flags.atSecond && flags.code == CODE_KEY2) nextState = S_UNL2;
        end
        S_UNL2: begin
          if (flags.atFirst) begin
            unique case (flags.code)
              CODE_PROG:  nextState = S_PROG;
              CODE_ERASE: nextState = S_ERS3;
              CODE_IDENT: strobe.setId = 1'b1;
              CODE_EXIT:  strobe.clrId = 1'b1;
              default:    nextState = S_IDLE;
            endcase
          end
        end
        S_PROG: begin
          strobe.op   = OP_PROG;
          strobe.fire = wpN | ~flags.protSector;
        end
        S_ERS3: begin
          if (flags.atFirst && flags.code == CODE_KEY1) nextState = S_ERS4;
        end
        S_ERS4: begin
          if (flags.atSecond && flags.code == CODE_KEY2) nextState = S_ERS5;
        end
        S_ERS5: begin
          if (flags.atFirst && flags.code == CODE_CHIP) begin
            strobe.op   = OP_CHIP;
            strobe.fire = wpN;
          end else if (flags.code == CODE_SECT) begin
            strobe.op   = OP_SECT;
            strobe.fire = wpN | ~flags.protSector;
          end else if (flags.code == CODE_BLK) begin
            strobe.op   = OP_BLK;
            strobe.fire = wpN | ~flags.protBlock;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/flashcmd_datapath.sv
module flashcmd_datapath
  import flashcmd_pkg::*;
#(
  parameter int          ADDR_W       = 20,
  parameter int          DATA_W       = 16,
  parameter int          SECTOR_AW    = 11,
  parameter int          BLOCK_AW     = 15,
  parameter int          PROT_SECTORS = 4,
  parameter bit          PROT_TOP     = 1'b0,
  parameter logic [15:0] DEV_ID       = 16'h7343,
  parameter logic [15:0] MFR_ID       = 16'h00A7
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              idSel,
  input  ctrlStrobe_t       strobe,
  output busFlags_t         flags,
  output logic              cmdValid,
  output cmdOp_e            cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              idMode,
  output logic [15:0]       idWord
);

  localparam logic [ADDR_W-1:0] PROT_LOW_LIMIT = ADDR_W'(PROT_SECTORS) << SECTOR_AW;
  localparam logic [ADDR_W-1:0] PROT_HIGH_BASE = ~PROT_LOW_LIMIT + 1'b1;

  logic protSector, protBlock;

  generate
    if (PROT_TOP) begin : g_protTop
      assign protSector = wrAddr >= PROT_HIGH_BASE;
      assign protBlock  = &wrAddr[ADDR_W-1:BLOCK_AW];
    end else begin : g_protBottom
      assign protSector = wrAddr < PROT_LOW_LIMIT;
      assign protBlock  = ~|wrAddr[ADDR_W-1:BLOCK_AW];
    end
  endgenerate

  assign flags.atFirst    = wrAddr[UNLOCK_AW-1:0] == UNLOCK_FIRST;
  assign flags.atSecond   = wrAddr[UNLOCK_AW-1:0] == UNLOCK_SECOND;
  assign flags.code       = wrData[7:0];
  assign flags.protSector = protSector;
  assign flags.protBlock  = protBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdOp    <= OP_NONE;
      cmdAddr  <= '0;
      cmdData  <= '0;
    end else if (strobe.fire) begin
      cmdValid <= 1'b1;
      cmdOp    <= strobe.op;
      cmdAddr  <= (strobe.op == OP_CHIP) ? '0 : wrAddr;
      cmdData  <= (strobe.op == OP_PROG) ? wrData : '0;
    end else begin
      cmdValid <= 1'b0;
      cmdOp    <= OP_NONE;
      cmdAddr  <= '0;
      cmdData  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             idMode <= 1'b0;
    else if (strobe.setId) idMode <= 1'b1;
    else if (strobe.clrId) idMode <= 1'b0;
  end

  assign idWord = idMode ? (idSel ? DEV_ID : MFR_ID) : 16'h0000;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flashcmd_pkg::*;
#(
  parameter int          ADDR_W       = 20,
  parameter int          DATA_W       = 16,
  parameter int          SECTOR_AW    = 11,
  parameter int          BLOCK_AW     = 15,
  parameter int          PROT_SECTORS = 4,
  parameter bit          PROT_TOP     = 1'b0,
  parameter logic [15:0] DEV_ID       = 16'h7343,
  parameter logic [15:0] MFR_ID       = 16'h00A7
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpN,
  input  logic              busy,
  input  logic              idSel,
  output logic              cmdValid,
  output logic [2:0]        cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              idMode,
  output logic [15:0]       idWord
);

  busFlags_t   flags;
  ctrlStrobe_t strobe;
  cmdOp_e      cmdOpQ;

  flashcmd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .busy   (busy),
    .wpN    (wpN),
    .flags  (flags),
    .strobe (strobe)
  );

  flashcmd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_AW(SECTOR_AW), .BLOCK_AW(BLOCK_AW),
    .PROT_SECTORS(PROT_SECTORS), .PROT_TOP(PROT_TOP), .DEV_ID(DEV_ID), .MFR_ID(MFR_ID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .idSel    (idSel),
    .strobe   (strobe),
    .flags    (flags),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOpQ),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .idMode   (idMode),
    .idWord   (idWord)
  );

  assign cmdOp = cmdOpQ;

endmodule

// File: rtl/flashcmd_chk.sv
module flashcmd_chk #(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_AW    = 11,
  parameter int PROT_SECTORS = 4,
  parameter bit PROT_TOP     = 1'b0
)(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              busy,
  input logic              wpN,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              idMode
);

  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(PROT_SECTORS) << SECTOR_AW;
  localparam logic [ADDR_W-1:0] HIGH_BASE = ~LOW_LIMIT + 1'b1;

  logic targetProtected;
  assign targetProtected = PROT_TOP ? (cmdAddr >= HIGH_BASE) : (cmdAddr < LOW_LIMIT);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !cmdValid);

  // R2
  accepted_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(wrEn && !busy));

  // R9
  prot_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 3'd1 || cmdOp == 3'd2) && !$past(wpN)) |-> !targetProtected);

  // R9
  chip_wp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd4) |-> $past(wpN));

  // R6
  id_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && !busy) |-> $stable(idMode));

endmodule

bind flash_cmd_decoder flashcmd_chk #(
  .ADDR_W(ADDR_W), .SECTOR_AW(SECTOR_AW), .PROT_SECTORS(PROT_SECTORS), .PROT_TOP(PROT_TOP)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .busy(busy), .wpN(wpN),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .idMode(idMode)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [19:0] a;
    logic [15:0] d;
    logic        wp;
    logic        eV;
    logic [2:0]  eOp;
    logic [19:0] eA;
    logic [15:0] eD;
    logic        eId;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VEC [NV] = '{
    // R2 word program
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd2},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd2},
    '{20'h00555, 16'h00A0, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd2},
    '{20'h40000, 16'h1234, 1'b1, 1'b1, 3'd1, 20'h40000, 16'h1234, 1'b0, 8'd2},
    // R3 chip erase
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd3},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd3},
    '{20'h00555, 16'h0080, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd3},
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd3},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd3},
    '{20'h00555, 16'h0010, 1'b1, 1'b1, 3'd4, 20'h0,     16'h0,    1'b0, 8'd3},
    // R7 sector erase with junk in upper data byte and upper address bits
    '{20'h7F555, 16'h12AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd7},
    '{20'h802AA, 16'h3455, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd7},
    '{20'h00555, 16'hFF80, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd7},
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd7},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd7},
    '{20'h23456, 16'h9930, 1'b1, 1'b1, 3'd2, 20'h23456, 16'h0,    1'b0, 8'd4},
    // R4 block erase
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd4},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd4},
    '{20'h00555, 16'h0080, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd4},
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd4},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd4},
    '{20'h48000, 16'h0050, 1'b1, 1'b1, 3'd3, 20'h48000, 16'h0,    1'b0, 8'd4},
    // R5 ID entry, R6 single-write exit
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd5},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd5},
    '{20'h00555, 16'h0090, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b1, 8'd5},
    '{20'h12345, 16'h00F0, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd6},
    // R5 entry again, R6 three-write exit
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd5},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd5},
    '{20'h00555, 16'h0090, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b1, 8'd5},
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b1, 8'd6},
    '{20'h002AA, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b1, 8'd6},
    '{20'h00555, 16'h00F0, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd6},
    // R8 broken sequence
    '{20'h00555, 16'h00AA, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd8},
    '{20'h002AB, 16'h0055, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd8},
    '{20'h00555, 16'h00A0, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd8},
    '{20'h40010, 16'h5678, 1'b1, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd8},
    // R9 protected program rejected, boundary accepted, protected block rejected
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h002AA, 16'h0055, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h00555, 16'h00A0, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h01FFF, 16'hBEEF, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h002AA, 16'h0055, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h00555, 16'h00A0, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h02000, 16'hBEEF, 1'b0, 1'b1, 3'd1, 20'h02000, 16'hBEEF, 1'b0, 8'd9},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h002AA, 16'h0055, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h00555, 16'h0080, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h002AA, 16'h0055, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9},
    '{20'h04000, 16'h0050, 1'b0, 1'b0, 3'd0, 20'h0,     16'h0,    1'b0, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        wpN = 1'b1;
  logic        busy = 1'b0;
  logic        idSel = 1'b0;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic [19:0] cmdAddr;
  logic [15:0] cmdData;
  logic        idMode;
  logic [15:0] idWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wpN(wpN), .busy(busy), .idSel(idSel), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .idMode(idMode), .idWord(idWord)
  );

  task automatic checkOut(input int req, input logic eV, input logic [2:0] eOp,
                          input logic [19:0] eA, input logic [15:0] eD, input logic eId);
    checks++;
    if (cmdValid !== eV || cmdOp !== eOp || cmdAddr !== eA || cmdData !== eD || idMode !== eId) begin
      errors++;
      $display("FAIL R%0d: got v=%b op=%0d a=%h d=%h id=%b, expected v=%b op=%0d a=%h d=%h id=%b",
               req, cmdValid, cmdOp, cmdAddr, cmdData, idMode, eV, eOp, eA, eD, eId);
    end
  endtask

  task automatic checkWord(input int req, input logic [15:0] exp);
    checks++;
    if (idWord !== exp) begin
      errors++;
      $display("FAIL R%0d: idWord got %h expected %h", req, idWord, exp);
    end
  endtask

  // One write cycle; result is sampled at the following falling edge.
  task automatic doWrite(input logic [19:0] a, input logic [15:0] d, input logic wp, input logic bsy);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wpN = wp; busy = bsy;
    @(negedge clk);
    wrEn = 1'b0; busy = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkOut(1, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i].a, VEC[i].d, VEC[i].wp, 1'b0);
      checkOut(VEC[i].req, VEC[i].eV, VEC[i].eOp, VEC[i].eA, VEC[i].eD, VEC[i].eId);
    end
    wpN = 1'b1;

    // R9 protected program accepted when wpN high; R11 pulse lasts one cycle
    doWrite(20'h00555, 16'h00AA, 1'b1, 1'b0);
    doWrite(20'h002AA, 16'h0055, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h00A0, 1'b1, 1'b0);
    doWrite(20'h01FFF, 16'hC0DE, 1'b1, 1'b0);
    checkOut(9, 1'b1, 3'd1, 20'h01FFF, 16'hC0DE, 1'b0);
    @(negedge clk);
    checkOut(11, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);

    // R10 busy writes ignored, sequence position held
    doWrite(20'h00555, 16'h00AA, 1'b1, 1'b0);
    doWrite(20'h002AA, 16'h0055, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h00A0, 1'b1, 1'b1);
    checkOut(10, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);
    doWrite(20'h00555, 16'h00A0, 1'b1, 1'b0);
    doWrite(20'h30000, 16'hAAAA, 1'b1, 1'b1);
    checkOut(10, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);
    doWrite(20'h30000, 16'h5A5A, 1'b1, 1'b0);
    checkOut(10, 1'b1, 3'd1, 20'h30000, 16'h5A5A, 1'b0);

    // R5 identification words
    checkWord(5, 16'h0000);
    doWrite(20'h00555, 16'h00AA, 1'b1, 1'b0);
    doWrite(20'h002AA, 16'h0055, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h0090, 1'b1, 1'b0);
    idSel = 1'b1; #1;
    checkWord(5, 16'h7343);
    idSel = 1'b0; #1;
    checkWord(5, 16'h00A7);

    // R1 asynchronous reset in the middle of a sequence while in ID mode
    doWrite(20'h00555, 16'h00AA, 1'b1, 1'b0);
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    checkOut(1, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);
    checkWord(1, 16'h0000);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doWrite(20'h002AA, 16'h0055, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h00A0, 1'b1, 1'b0);
    doWrite(20'h40000, 16'h1234, 1'b1, 1'b0);
    checkOut(1, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);

    // R8 a broken erase sequence drops the pending sixth write
    doWrite(20'h00555, 16'h00AA, 1'b1, 1'b0);
    doWrite(20'h002AA, 16'h0055, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h0080, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h00AB, 1'b1, 1'b0);
    doWrite(20'h00555, 16'h0010, 1'b1, 1'b0);
    checkOut(8, 1'b0, 3'd0, 20'h0, 16'h0, 1'b0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule